// File: doc/BRIEF.md
# Monitor Channel Transmit Handshake

This block is the responding side of a byte-wide monitor channel during the return of read data. Bytes arrive from a local valid/ready source. Each byte is placed on the upstream monitor byte and framed by an active-low upstream MX bit. The host acknowledges on an active-low downstream MR bit. After each acknowledge the block releases MX for exactly one frame. It then either raises MX again for the next byte or holds MX released for a second frame to close the message. The message closes whenever the source has no byte ready at the moment of the acknowledge.

All protocol state moves only on a one-cycle frame strobe. While the block holds a byte, the host must send the all-ones idle value downstream. Any other value is treated as a collision and ends the message at once. If the host withholds MR, the block aborts and reports it. A new message starts only after the channel has been quiet for two frame strobes.

Back-pressure rules on the source side: `src_ready` is high only in a strobe cycle where the block can accept a byte, and it does not depend on `src_valid`. A byte moves only when both are high on the same clock edge. The source must keep `src_valid` and `src_data` stable until that edge.

Top module: `mtx_monitor_tx`

## Requirements
- R1: After reset, `mx_up_n` is 1, `mon_up` is all ones, and `abort_collision`, `abort_host` and `msg_done` are 0.
- R2: `mx_up_n` and `mon_up` change only in the clock cycle that follows a `frame_tick` cycle, and `src_ready` is high only while `frame_tick` is high.
- R3: From idle, a byte is taken only at a strobe where MR was sampled inactive (1) at each of the two previous strobes taken while idle and `src_valid` is high. An active MR sample, or any strobe outside idle, restarts that count.
- R4: A newly started message first shows its byte on `mon_up` with `mx_up_n` = 1 for one frame, then drives `mx_up_n` to 0. The byte stays unchanged while MX is active.
- R5: An acknowledge is an MR sample of 1 followed by an MR sample of 0 at the next strobe while MX is active. MR held at 0 across strobes is not an acknowledge, and MX stays active.
- R6: No byte is taken from the source while a byte awaits acknowledge. At the acknowledge strobe, if `src_valid` is high, the next byte is taken and shown with `mx_up_n` = 1 for exactly one frame, then `mx_up_n` returns to 0.
- R7: At an acknowledge with no source byte, `mx_up_n` stays 1 and `mon_up` is all ones for two frames. `msg_done` then pulses for one clock after the strobe that ends the second frame.
- R8: While a byte is held on `mon_up` (lead frame, MX active, or a gap with a next byte), a downstream byte other than all ones at a strobe pulses `abort_collision`. It also forces `mx_up_n` to 1 and `mon_up` to all ones, and returns the block to idle.
- R9: MR sampled inactive at two consecutive strobes while MX is active pulses `abort_host`, sets `mx_up_n` to 1 and `mon_up` to all ones, and returns the block to idle.
- R10: Only one of `abort_collision`, `abort_host`, `msg_done` is high in any cycle, and each is high for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe marking a frame boundary |
| src_valid | input | 1 | Source byte available |
| src_data | input | DATA_W | Source byte |
| src_ready | output | 1 | Block accepts the source byte this cycle |
| mr_dn_n | input | 1 | Downstream MR, active low |
| mon_dn | input | DATA_W | Downstream monitor byte |
| mx_up_n | output | 1 | Upstream MX, active low |
| mon_up | output | DATA_W | Upstream monitor byte |
| abort_collision | output | 1 | Pulse: non-idle downstream byte while holding data |
| abort_host | output | 1 | Pulse: host withheld MR |
| msg_done | output | 1 | Pulse: end-of-message completed |

## Verification
Every registered result (`mx_up_n`, `mon_up` and the three pulses) is due one clock after the strobe cycle that causes it. `src_ready` is due in the strobe cycle itself. The bench drives MR and the downstream byte a few clocks ahead of each strobe and raises `frame_tick` for one cycle at a falling edge. It then compares the outputs at the next falling edge, half a clock after the register update, while the pulses are still high. Source transfers are counted on the rising edges where `src_valid` and `src_ready` meet, so acceptance can be compared frame by frame.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_SEND = 3'd2,
    ST_GAP  = 3'd3,
    ST_END  = 3'd4
  } mtx_state_e;
endpackage

// File: rtl/mtx_mr_track.sv
module mtx_mr_track #(
  parameter int QUIET_FRAMES   = 2,
  parameter int MR_LOSS_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mr_n,
  input  logic in_idle,
  input  logic in_send,
  output logic ack,
  output logic host_lost,
  output logic quiet_ok
);
  localparam int QW = $clog2(QUIET_FRAMES + 1);
  localparam int LW = $clog2(MR_LOSS_FRAMES + 1);
  localparam logic [QW-1:0] QMAX  = QW'(QUIET_FRAMES);
  localparam logic [LW-1:0] LLAST = LW'(MR_LOSS_FRAMES - 1);
  localparam logic [LW-1:0] LMAX  = LW'(MR_LOSS_FRAMES);

  logic          mr_prev;
  logic [QW-1:0] quiet_cnt;
  logic [LW-1:0] loss_cnt;

  // previous strobe sample of MR
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mr_prev <= 1'b1;
    else if (tick) mr_prev <= mr_n;
  end

  // quiet-channel counter, only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_cnt <= '0;
    else if (tick) begin
      if (in_idle && mr_n) quiet_cnt <= (quiet_cnt == QMAX) ? quiet_cnt : quiet_cnt + 1'b1;
      else                 quiet_cnt <= '0;
    end
  end

  // run of inactive MR samples while MX is active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loss_cnt <= '0;
    else if (tick) begin
      if (in_send && mr_n) loss_cnt <= (loss_cnt == LMAX) ? loss_cnt : loss_cnt + 1'b1;
      else                 loss_cnt <= '0;
    end
  end

  assign ack       = tick & in_send & mr_prev & ~mr_n;
  assign host_lost = tick & in_send & mr_n & (loss_cnt == LLAST);
  assign quiet_ok  = (quiet_cnt == QMAX);
endmodule

// File: rtl/mtx_idle_cmp.sv
module mtx_idle_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              tick,
  input  logic              armed,
  input  logic [DATA_W-1:0] mon_dn,
  output logic              hit
);
  localparam logic [DATA_W-1:0] IDLE_BYTE = {DATA_W{1'b1}};
  assign hit = tick & armed & (mon_dn != IDLE_BYTE);
endmodule

// File: rtl/mtx_tx_fsm.sv
module mtx_tx_fsm
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              ack,
  input  logic              host_lost,
  input  logic              collide,
  input  logic              quiet_ok,
  output logic              src_ready,
  output logic              mx_n,
  output logic [DATA_W-1:0] mon_up,
  output logic              armed,
  output logic              in_idle,
  output logic              in_send,
  output logic              coll_pulse,
  output logic              host_pulse,
  output logic              done_pulse
);
  localparam logic [DATA_W-1:0] IDLE_BYTE = {DATA_W{1'b1}};

  mtx_state_e state;
  logic       more;

  assign in_idle   = (state == ST_IDLE);
  assign in_send   = (state == ST_SEND);
  assign src_ready = (tick & in_idle & quiet_ok) | (ack & ~collide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      more       <= 1'b0;
      mx_n       <= 1'b1;
      mon_up     <= IDLE_BYTE;
      armed      <= 1'b0;
      coll_pulse <= 1'b0;
      host_pulse <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      coll_pulse <= 1'b0;
      host_pulse <= 1'b0;
      done_pulse <= 1'b0;
      if (tick) begin
        if (collide) begin
          state      <= ST_IDLE;
          more       <= 1'b0;
          mx_n       <= 1'b1;
          mon_up     <= IDLE_BYTE;
          armed      <= 1'b0;
          coll_pulse <= 1'b1;
        end else begin
          unique case (state)
            ST_IDLE: if (quiet_ok && src_valid) begin
              state  <= ST_LEAD;
              mon_up <= src_data;
              armed  <= 1'b1;
            end
            ST_LEAD: begin
              state <= ST_SEND;
              mx_n  <= 1'b0;
            end
            ST_SEND: begin
              if (host_lost) begin
                state      <= ST_IDLE;
                mx_n       <= 1'b1;
                mon_up     <= IDLE_BYTE;
                armed      <= 1'b0;
                host_pulse <= 1'b1;
              end else if (ack) begin
                state <= ST_GAP;
                mx_n  <= 1'b1;
                if (src_valid) begin
                  mon_up <= src_data;
                  more   <= 1'b1;
                  armed  <= 1'b1;
                end else begin
                  mon_up <= IDLE_BYTE;
                  more   <= 1'b0;
                  armed  <= 1'b0;
                end
              end
            end
            ST_GAP: begin
              if (more) begin
                state <= ST_SEND;
                mx_n  <= 1'b0;
              end else begin
                state <= ST_END;
              end
            end
            ST_END: begin
              state      <= ST_IDLE;
              done_pulse <= 1'b1;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mtx_monitor_tx.sv
module mtx_monitor_tx #(
  parameter int DATA_W         = 8,
  parameter int QUIET_FRAMES   = 2,
  parameter int MR_LOSS_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              mr_dn_n,
  input  logic [DATA_W-1:0] mon_dn,
  output logic              mx_up_n,
  output logic [DATA_W-1:0] mon_up,
  output logic              abort_collision,
  output logic              abort_host,
  output logic              msg_done
);
  logic ack, host_lost, quiet_ok, collide, armed, in_idle, in_send;

  mtx_mr_track #(
    .QUIET_FRAMES  (QUIET_FRAMES),
    .MR_LOSS_FRAMES(MR_LOSS_FRAMES)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frame_tick),
    .mr_n     (mr_dn_n),
    .in_idle  (in_idle),
    .in_send  (in_send),
    .ack      (ack),
    .host_lost(host_lost),
    .quiet_ok (quiet_ok)
  );

  mtx_idle_cmp #(.DATA_W(DATA_W)) u_cmp (
    .tick  (frame_tick),
    .armed (armed),
    .mon_dn(mon_dn),
    .hit   (collide)
  );

  mtx_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (frame_tick),
    .src_valid (src_valid),
    .src_data  (src_data),
    .ack       (ack),
    .host_lost (host_lost),
    .collide   (collide),
    .quiet_ok  (quiet_ok),
    .src_ready (src_ready),
    .mx_n      (mx_up_n),
    .mon_up    (mon_up),
    .armed     (armed),
    .in_idle   (in_idle),
    .in_send   (in_send),
    .coll_pulse(abort_collision),
    .host_pulse(abort_host),
    .done_pulse(msg_done)
  );
endmodule

// File: rtl/mtx_monitor_tx_chk.sv
module mtx_monitor_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              src_ready,
  input logic              mr_dn_n,
  input logic              mx_up_n,
  input logic [DATA_W-1:0] mon_up,
  input logic              abort_collision,
  input logic              abort_host,
  input logic              msg_done
);
  AST_MX_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(mx_up_n)); // R2
  AST_BYTE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(mon_up)); // R2
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> frame_tick); // R2
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mx_up_n && $past(!mx_up_n)) |-> $stable(mon_up)); // R4
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort_collision, abort_host, msg_done})); // R10
  AST_COLL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_collision |-> (mx_up_n && mon_up == {DATA_W{1'b1}})); // R8
  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_host |-> (mx_up_n && mon_up == {DATA_W{1'b1}})); // R9
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_collision || abort_host || msg_done) |=> !(abort_collision || abort_host || msg_done)); // R10
endmodule

bind mtx_monitor_tx mtx_monitor_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_tick     (frame_tick),
  .src_ready      (src_ready),
  .mr_dn_n        (mr_dn_n),
  .mx_up_n        (mx_up_n),
  .mon_up         (mon_up),
  .abort_collision(abort_collision),
  .abort_host     (abort_host),
  .msg_done       (msg_done)
);

// File: tb/mtx_monitor_tx_test.sv
module mtx_monitor_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic       src_valid, src_ready;
  logic [7:0] src_data;
  logic       mr_dn_n = 1'b1;
  logic [7:0] mon_dn = 8'hFF;
  logic       mx_up_n;
  logic [7:0] mon_up;
  logic       abort_collision, abort_host, msg_done;

  logic [7:0] fifo [0:63];
  int         head = 0;
  int         tail = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done_run = 1'b0;

  always #2 clk = ~clk;

  assign src_valid = (head != tail);
  assign src_data  = fifo[head[5:0]];

  always @(posedge clk) if (src_valid && src_ready) head <= head + 1;

  mtx_monitor_tx uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .mr_dn_n(mr_dn_n), .mon_dn(mon_dn), .mx_up_n(mx_up_n), .mon_up(mon_up),
    .abort_collision(abort_collision), .abort_host(abort_host), .msg_done(msg_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic mr, input logic [7:0] dn);
    @(negedge clk);
    mr_dn_n = mr;
    mon_dn  = dn;
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    fifo[tail[5:0]] = b;
    tail = tail + 1;
  endtask

  task automatic settle();
    tail = head;
    for (int i = 0; i < 3; i++) frame(1'b1, 8'hFF);
  endtask

  task automatic t_reset();
    chk("R1 mx", mx_up_n, 1);
    chk("R1 mon", mon_up, 8'hFF);
    chk("R1 pulses", {abort_collision, abort_host, msg_done}, 0);
  endtask

  task automatic t_single();
    int h0;
    settle();
    h0 = head;
    push(8'hA5);
    frame(1'b1, 8'hFF);
    chk("R4 lead byte", mon_up, 8'hA5);
    chk("R4 lead mx", mx_up_n, 1);
    chk("R3 taken", head - h0, 1);
    frame(1'b1, 8'hFF);
    chk("R4 mx active", mx_up_n, 0);
    frame(1'b1, 8'hFF);
    chk("R4 still held", mon_up, 8'hA5);
    chk("R9 one miss ok", mx_up_n, 0);
    frame(1'b0, 8'hFF);
    chk("R7 gap mx", mx_up_n, 1);
    chk("R7 gap mon", mon_up, 8'hFF);
    frame(1'b0, 8'hFF);
    chk("R7 end mx", mx_up_n, 1);
    chk("R7 no early done", msg_done, 0);
    frame(1'b0, 8'hFF);
    chk("R7 done", msg_done, 1);
    chk("R10 only done", {abort_collision, abort_host}, 0);
  endtask

  task automatic t_quiet();
    int h0;
    h0 = head;
    push(8'h5C);
    frame(1'b1, 8'hFF);
    chk("R3 wait q1", head - h0, 0);
    frame(1'b0, 8'hFF);
    chk("R3 mr active", head - h0, 0);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'hFF);
    chk("R3 wait q2", head - h0, 0);
    chk("R3 idle mx", mx_up_n, 1);
    frame(1'b1, 8'hFF);
    chk("R3 start", head - h0, 1);
    chk("R3 lead byte", mon_up, 8'h5C);
    frame(1'b1, 8'hFF);
    frame(1'b0, 8'hFF);
    frame(1'b0, 8'hFF);
    frame(1'b0, 8'hFF);
    chk("R7 done q", msg_done, 1);
  endtask

  task automatic t_two();
    int h0;
    settle();
    h0 = head;
    push(8'h3C);
    push(8'hC3);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'hFF);
    chk("R6 no pull before ack", head - h0, 1);
    frame(1'b0, 8'hFF);
    chk("R6 gap byte", mon_up, 8'hC3);
    chk("R6 gap mx", mx_up_n, 1);
    chk("R6 pulled", head - h0, 2);
    frame(1'b0, 8'hFF);
    chk("R6 mx again", mx_up_n, 0);
    chk("R6 byte again", mon_up, 8'hC3);
    frame(1'b1, 8'hFF);
    frame(1'b0, 8'hFF);
    chk("R7 gap2", mon_up, 8'hFF);
    frame(1'b0, 8'hFF);
    frame(1'b0, 8'hFF);
    chk("R7 done2", msg_done, 1);
  endtask

  task automatic t_coll_lead();
    int h0;
    settle();
    h0 = head;
    push(8'h12);
    push(8'h34);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'h00);
    chk("R8 lead pulse", abort_collision, 1);
    chk("R8 lead mx", mx_up_n, 1);
    chk("R8 lead mon", mon_up, 8'hFF);
    chk("R8 no pull", head - h0, 1);
  endtask

  task automatic t_coll_send();
    settle();
    push(8'h77);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'hFE);
    chk("R8 send pulse", abort_collision, 1);
    chk("R8 send mx", mx_up_n, 1);
    chk("R10 no host", abort_host, 0);
  endtask

  task automatic t_host();
    settle();
    push(8'h66);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'hFF);
    chk("R9 after one", abort_host, 0);
    frame(1'b1, 8'hFF);
    chk("R9 pulse", abort_host, 1);
    chk("R9 mx", mx_up_n, 1);
    chk("R9 mon", mon_up, 8'hFF);
  endtask

  task automatic t_held_mr();
    int h0;
    settle();
    h0 = head;
    push(8'h11);
    push(8'h22);
    push(8'h33);
    frame(1'b1, 8'hFF);
    frame(1'b1, 8'hFF);
    frame(1'b0, 8'hFF);
    frame(1'b0, 8'hFF);
    chk("R5 second mx", mx_up_n, 0);
    frame(1'b0, 8'hFF);
    frame(1'b0, 8'hFF);
    chk("R5 held mr no ack", mx_up_n, 0);
    chk("R5 byte kept", mon_up, 8'h22);
    chk("R6 no pull held", head - h0, 2);
    frame(1'b1, 8'hFF);
    frame(1'b0, 8'hFF);
    chk("R5 edge ack", mon_up, 8'h33);
    frame(1'b0, 8'h5A);
    chk("R8 gap pulse", abort_collision, 1);
    chk("R8 gap mon", mon_up, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_quiet();
    t_two();
    t_coll_lead();
    t_coll_send();
    t_host();
    t_held_mr();
    done_run = 1'b1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule